// File: doc/BRIEF.md
# Granule Tag Range Checker

This block decides whether a memory access may proceed under granule tagging. Memory is split into 16-byte granules and each granule owns a 4-bit allocation tag. Tags are kept two to a byte in a separate tag store: the even granule of a 32-byte pair sits in the low nibble and the odd granule sits in the high nibble. The block receives the start address of an access and its size (1 to 256 bytes), and it takes the expected tag from bits 59:56 of that address. It then walks every granule the access touches and reports whether all of their stored tags equal the pointer tag.

A caller pulses `start_i` with the address, the size minus one and a check-enable bit. If checking is disabled, the block reports a pass one cycle later and reads no tags. Otherwise it reads one tag byte at a time through a synchronous read port that returns data one cycle after the request. It compares both nibbles of each byte in a single cycle and stops at the first mismatch or when the last covered granule has been checked. When it finishes, it pulses `done_o` and presents `pass_o` and `fault_addr_o`. The fault address is the first byte of the failing granule, except when the first granule fails: in that case it is the start address itself.

Top module: `granule_tag_checker`

## Requirements
- R1: The number of granules checked is floor((start mod 16 + size − 1) / 16) + 1, so it ranges from 1 to 17.
- R2: The granule with index g = start >> 4 maps to tag byte g >> 1, which is byte address bits [TAG_AW+4:5]. Address bit 4 selects bits 3:0 (bit 4 = 0) or bits 7:4 (bit 4 = 1) of that byte. Successive bytes are read at consecutive tag addresses.
- R3: When start bit 4 is set, the first byte is checked from its high nibble only, and its low nibble has no effect on the result.
- R4: Granules are checked in ascending address order, and checking stops at the first mismatch. The result is a pass exactly when all covered granules match. Tags of granules outside the access have no effect.
- R5: On a failure in granule 0 the fault address is the start address. On a failure in granule n > 0 it is (start with bits 3:0 cleared) + 16·n. On a pass it is the start address.
- R6: The pointer tag compared against memory is address bits 59:56.
- R7: With check_en_i low at start, the block pulses done_o with pass_o high on the next edge, issues no tag read, and reports the start address.
- R8: Each tag byte costs two cycles. tag_rd_en_o is high for exactly one cycle per byte, and read data is taken on the following edge. Counting the start edge as edge 1, done_o is high after edge 2B+1, where B is the number of bytes examined up to the stopping granule.
- R9: start_i is ignored while busy_o is high, and the running check completes with its own result.
- R10: After reset the block is idle, with done_o, busy_o and tag_rd_en_o low.
- R11: done_o is a one-cycle pulse for each accepted start, and pass_o and fault_addr_o are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a check; taken only when idle |
| addr_i | input | 64 | Access start address, with the pointer tag in bits 59:56 |
| size_m1_i | input | SIZE_W (8) | Access size in bytes minus one |
| check_en_i | input | 1 | 1 = check tags, 0 = pass the access as unchecked |
| tag_rd_en_o | output | 1 | Tag store read request |
| tag_rd_addr_o | output | TAG_AW (12) | Tag store byte address |
| tag_rd_data_i | input | 8 | Tag byte, valid the cycle after the request |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Access passed; valid with done_o |
| fault_addr_o | output | 64 | Fault address (start address on a pass); valid with done_o |

## Verification
The bench sweeps every start offset inside a 48-byte window against sizes chosen to fall just short of, exactly on, and just past granule and pair boundaries, up to the full 256 bytes. For each case it plants a mismatch at the first granule, at the second granule, at the last granule, or at none of them, and it also plants wrong tags in the granules just outside the access. A wrong granule count would then pick up one of the neighbouring bad tags or miss the planted one. Starting on the wrong nibble of an odd-aligned access would fail on the bad tag placed just before the access. Returning the granule base instead of the start address for a first-granule fault would be caught on every unaligned start. The latency, the sequence of read addresses, starts issued while busy and unchecked accesses are each compared against values the bench derives from the requirements.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned GRAN_LG = 4;   // 16-byte granule
  localparam int unsigned TAG_LSB = 56;  // pointer tag field 59:56

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_CMP} gtc_state_e;

  // Pointer tag carried in the upper address bits (R6)
  function automatic logic [3:0] ptr_tag(addr_t a);
    return a[TAG_LSB +: 4];
  endfunction

  // Fault address for the n-th covered granule (R5)
  function automatic addr_t fault_address(addr_t start, int unsigned n);
    addr_t base;
    base = {start[ADDR_W-1:GRAN_LG], {GRAN_LG{1'b0}}};
    if (n == 0) return start;
    return base + (addr_t'(n) << GRAN_LG);
  endfunction
endpackage

// File: rtl/gtc_span.sv
module gtc_span #(
  parameter int unsigned SIZE_W = 8,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned TAG_AW = 12,
  localparam int unsigned LO_W  = TAG_AW + 5
) (
  input  logic [LO_W-1:0]   addr_lo,
  input  logic [SIZE_W-1:0] size_m1,
  output logic [CNT_W-1:0]  gran_count,
  output logic [TAG_AW-1:0] first_byte,
  output logic              odd_start
);
  logic [SIZE_W:0] reach;

  // Offset inside the first granule plus the size minus one (R1)
  always_comb begin
    reach      = {1'b0, size_m1} + (SIZE_W+1)'(addr_lo[3:0]);
    gran_count = CNT_W'(reach >> 4) + CNT_W'(1);
  end

  // Two granules per tag byte (R2), odd granule in high nibble (R3)
  assign first_byte = addr_lo[5 +: TAG_AW];
  assign odd_start  = addr_lo[4];
endmodule

// File: rtl/gtc_nibble_cmp.sv
module gtc_nibble_cmp #(
  parameter int unsigned CNT_W = 5
) (
  input  logic [7:0]       tag_byte,
  input  logic [3:0]       ptag,
  input  logic             skip_lo,
  input  logic [CNT_W-1:0] matched,
  input  logic [CNT_W-1:0] gran_count,
  output logic             stop,
  output logic             fail,
  output logic [CNT_W-1:0] matched_next
);
  logic [7:0]       diff;
  logic             lo_bad, hi_bad;
  logic [CNT_W-1:0] after_lo;

  // Replicate the pointer tag into both nibbles and compare the byte at once
  assign diff     = tag_byte ^ {ptag, ptag};
  assign lo_bad   = !skip_lo && (diff[3:0] != 4'h0);
  assign hi_bad   = diff[7:4] != 4'h0;
  assign after_lo = matched + (skip_lo ? CNT_W'(0) : CNT_W'(1));

  always_comb begin
    stop         = 1'b0;
    fail         = 1'b0;
    matched_next = after_lo;
    if (lo_bad) begin
      stop         = 1'b1;
      fail         = 1'b1;
      matched_next = matched;
    end else if (after_lo == gran_count) begin
      stop = 1'b1;
    end else if (hi_bad) begin
      stop = 1'b1;
      fail = 1'b1;
    end else begin
      matched_next = after_lo + CNT_W'(1);
      stop         = (matched_next == gran_count);
    end
  end
endmodule

// File: rtl/granule_tag_checker.sv
module granule_tag_checker
  import gtc_pkg::*;
#(
  parameter int unsigned TAG_AW    = 12,
  parameter int unsigned MAX_BYTES = 256,
  localparam int unsigned SIZE_W   = $clog2(MAX_BYTES),
  localparam int unsigned CNT_W    = $clog2(MAX_BYTES / 16 + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SIZE_W-1:0]   size_m1_i,
  input  logic                check_en_i,
  output logic                tag_rd_en_o,
  output logic [TAG_AW-1:0]   tag_rd_addr_o,
  input  logic [7:0]          tag_rd_data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                pass_o,
  output logic [ADDR_W-1:0]   fault_addr_o
);
  gtc_state_e        st_q;
  addr_t             start_q;
  logic [3:0]        ptag_q;
  logic [CNT_W-1:0]  cnt_q, matched_q;
  logic [TAG_AW-1:0] byte_q;
  logic              skip_lo_q;
  logic              done_q, pass_q;
  addr_t             fault_q;

  // Named internal events
  logic              accept;
  logic              accept_unchecked;
  logic              accept_checked;
  logic              in_cmp;
  logic [CNT_W-1:0]  span_count;
  logic [TAG_AW-1:0] span_first;
  logic              span_odd;
  logic              cmp_stop, cmp_fail;
  logic [CNT_W-1:0]  cmp_matched;

  assign accept           = start_i && (st_q == ST_IDLE);
  assign accept_unchecked = accept && !check_en_i;
  assign accept_checked   = accept && check_en_i;
  assign in_cmp           = (st_q == ST_CMP);

  gtc_span #(.SIZE_W(SIZE_W), .CNT_W(CNT_W), .TAG_AW(TAG_AW)) u_span (
    .addr_lo    (addr_i[TAG_AW+4:0]),
    .size_m1    (size_m1_i),
    .gran_count (span_count),
    .first_byte (span_first),
    .odd_start  (span_odd)
  );

  gtc_nibble_cmp #(.CNT_W(CNT_W)) u_cmp (
    .tag_byte     (tag_rd_data_i),
    .ptag         (ptag_q),
    .skip_lo      (skip_lo_q),
    .matched      (matched_q),
    .gran_count   (cnt_q),
    .stop         (cmp_stop),
    .fail         (cmp_fail),
    .matched_next (cmp_matched)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      start_q   <= '0;
      ptag_q    <= '0;
      cnt_q     <= '0;
      matched_q <= '0;
      byte_q    <= '0;
      skip_lo_q <= 1'b0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      fault_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept_unchecked) begin
            done_q  <= 1'b1;
            pass_q  <= 1'b1;
            fault_q <= addr_i;
          end else if (accept_checked) begin
            st_q      <= ST_REQ;
            start_q   <= addr_i;
            ptag_q    <= ptr_tag(addr_i);
            cnt_q     <= span_count;
            matched_q <= '0;
            byte_q    <= span_first;
            skip_lo_q <= span_odd;
          end
        end
        ST_REQ: st_q <= ST_CMP;
        ST_CMP: begin
          if (cmp_stop) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            pass_q  <= !cmp_fail;
            fault_q <= cmp_fail ? fault_address(start_q, 32'(cmp_matched))
                                : start_q;
          end else begin
            st_q      <= ST_REQ;
            matched_q <= cmp_matched;
            byte_q    <= byte_q + TAG_AW'(1);
            skip_lo_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tag_rd_en_o   = (st_q == ST_REQ);
  assign tag_rd_addr_o = byte_q;
  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign pass_o        = pass_q;
  assign fault_addr_o  = fault_q;

  // Reads are spaced: one request, then the compare cycle
  assert_read_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_rd_en_o |=> !tag_rd_en_o);

  // Unchecked access completes at once with a pass and no read
  assert_unchecked_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_unchecked |=> done_o && pass_o && !busy_o && !tag_rd_en_o);

  // Matched granules never exceed the covered count
  assert_matched_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (matched_q <= cnt_q));

  // A byte that does not end the walk is followed by a read of the next byte
  assert_next_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmp && !cmp_stop) |=> tag_rd_en_o && (tag_rd_addr_o == $past(byte_q) + TAG_AW'(1)));

  // A start while busy does not disturb the running walk
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !in_cmp) |=> busy_o && $stable(start_q));

  // Completion leaves the block idle
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/tb_granule_tag_checker.sv
module tb_granule_tag_checker;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_AW     = 8;
  localparam int SIZE_W     = 8;
  localparam int WATCHDOG   = 190000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [63:0]       addr_i = '0;
  logic [SIZE_W-1:0] size_m1_i = '0;
  logic              check_en_i = 1'b0;
  logic              tag_rd_en_o;
  logic [TAG_AW-1:0] tag_rd_addr_o;
  logic [7:0]        tag_rd_data_i;
  logic              busy_o, done_o, pass_o;
  logic [63:0]       fault_addr_o;

  logic [7:0] mem [256];
  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  granule_tag_checker #(.TAG_AW(TAG_AW), .MAX_BYTES(256)) dut (
    .clk, .rst_n, .start_i, .addr_i, .size_m1_i, .check_en_i,
    .tag_rd_en_o, .tag_rd_addr_o, .tag_rd_data_i,
    .busy_o, .done_o, .pass_o, .fault_addr_o
  );

  // Synchronous tag store model
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (tag_rd_en_o) tag_rd_data_i <= mem[tag_rd_addr_o];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void set_nib(longint unsigned g, logic [3:0] v);
    int b;
    b = int'((g >> 1) & 255);
    if (g[0]) mem[b][7:4] = v;
    else      mem[b][3:0] = v;
  endfunction

  // Run one access and compare against values derived from the requirements.
  // k: index of the planted mismatch granule, -1 for none.
  task automatic run(input longint unsigned a, input int size, input int k,
                     input bit en, input bit poke_busy);
    longint unsigned g0, cnt, exp_fault, glast, bytes, first_b;
    logic [3:0] pt;
    int cyc, reads, stop_g, rd_err;
    bit exp_pass;
    pt      = a[59:56];
    g0      = a >> 4;
    cnt     = (((a & 15) + longint'(size) - 1) >> 4) + 1;
    first_b = (a >> 5) & 255;
    for (int i = -2; i < 12; i++) mem[int'((first_b + longint'(i)) & 255)] = {pt, pt};
    set_nib(g0 - 1, pt ^ 4'h9);     // neighbour before the access (R4)
    set_nib(g0 + cnt, pt ^ 4'h6);   // neighbour after the access (R4)
    if (k >= 0) set_nib(g0 + longint'(k), pt ^ 4'h5);
    exp_pass  = (k < 0) || !en;
    stop_g    = (k < 0) ? int'(cnt) - 1 : k;
    exp_fault = (!en || k <= 0) ? a : ((a & ~64'hF) + 16 * longint'(k));
    glast     = g0 + longint'(stop_g);
    bytes     = en ? ((glast >> 1) - (g0 >> 1) + 1) : 0;

    @(negedge clk);
    addr_i = a; size_m1_i = SIZE_W'(size - 1); check_en_i = en; start_i = 1'b1;
    cyc = 0; reads = 0; rd_err = 0;
    while (cyc < 100) begin
      @(posedge clk);
      @(negedge clk);
      if (poke_busy && cyc == 0) begin
        addr_i = a ^ 64'h0F00_0000_0000_0040; check_en_i = 1'b0; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      cyc++;
      if (tag_rd_en_o) begin
        if (longint'(tag_rd_addr_o) != ((first_b + longint'(reads)) & 255)) rd_err++;
        reads++;
      end
      if (done_o) break;
    end
    start_i = 1'b0;
    chk(done_o === 1'b1, "R11", "done pulse", done_o, 1);
    chk(pass_o === exp_pass, "R4", "pass", pass_o, exp_pass);
    chk(fault_addr_o === exp_fault, "R5", "fault address", fault_addr_o, exp_fault);
    chk(longint'(cyc) == 2 * bytes + 1, en ? "R8" : "R7", "latency", cyc, 2 * bytes + 1);
    chk(longint'(reads) == bytes && rd_err == 0, "R2", "tag reads", reads, bytes);
    @(negedge clk);
    chk(done_o === 1'b0, "R11", "done single cycle", done_o, 0);
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int sizes [12] = '{1, 2, 15, 16, 17, 31, 32, 33, 48, 100, 255, 256};
    longint unsigned a;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(done_o === 1'b0 && busy_o === 1'b0 && tag_rd_en_o === 1'b0, "R10",
        "reset idle", {done_o, busy_o, tag_rd_en_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: offsets x sizes x mismatch position (R1..R6)
    for (int off = 0; off < 48; off++) begin
      for (int s = 0; s < 12; s++) begin
        for (int m = 0; m < 4; m++) begin
          int kk, cnt;
          a   = 64'h0000_0000_0000_1000 | (longint'((off + s + m) & 15) << 56)
                | longint'(off);
          cnt = int'((((a & 15) + longint'(sizes[s]) - 1) >> 4) + 1);
          kk  = (m == 0) ? -1 : (m == 1) ? 0 : (m == 2) ? 1 : cnt - 1;
          if (kk >= cnt) kk = -1;
          run(a, sizes[s], kk, 1'b1, 1'b0);
        end
      end
    end

    // R3: odd start with the even nibble of the first byte wrong still passes
    run(64'h0300_0000_0000_1010, 16, -1, 1'b1, 1'b0);
    // R6: tag field 59:56 decides, upper nibble 63:60 ignored
    run(64'hA500_0000_0000_1004, 40, -1, 1'b1, 1'b0);
    // R7: unchecked accesses pass even with a mismatch planted
    run(64'h0700_0000_0000_1008, 64, 0, 1'b0, 1'b0);
    run(64'h0200_0000_0000_1031, 256, 3, 1'b0, 1'b0);
    // R9: start while busy is ignored
    run(64'h0400_0000_0000_1006, 100, 2, 1'b1, 1'b1);
    run(64'h0900_0000_0000_1017, 60, -1, 1'b1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule